// File: doc/BRIEF.md
# Buffered UART Transmitter with Holding-Empty and Done Flags

This block is the transmit half of a serial port. Software writes bytes through a one-cycle write strobe into a single-entry holding register. A frame sequencer moves each byte into a shift register and sends it on a line that idles high. A frame is a low start bit, eight data bits least significant first, and a high stop bit. Every bit boundary falls on a baud tick supplied from outside, so one baud period is the time between two ticks.

Two flags tell software when to act. The holding-empty flag is high whenever the holding register can take a byte. It is level-based, so turning on its interrupt enable while it is high raises the interrupt at once. The done flag rises when the last frame has finished and nothing is waiting. It stays high until software clears it or writes another byte.

A release-mode input decides when a byte leaves the holding register:

- In early release, the byte moves to the shifter on the next clock.
- In late release, the byte stays held until the start bit has been on the line for a full baud period.

Late release lets software time events to the end of each start bit. For example, an all-ones byte shows on the line only as a one-period low pulse, so a run of such bytes acts as a timed delay whose end software sees through the flag.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, holdEmpty is 1, txDone is 0, overrun is 0 and txLine is 1.
- R2: Each frame on txLine is one 0 start bit, then 8 data bits with bit 0 first, then one 1 stop bit. Each bit lasts exactly one baud period, and the start bit begins on a baud tick.
- R3: emptyIrq equals holdEmpty AND emptyIrqEn, and doneIrq equals txDone AND doneIrqEn, in the same cycle and with no register in the path.
- R4: With lateRelease = 0 and the shifter idle, a byte accepted at clock edge k drives holdEmpty low after edge k, and holdEmpty returns high after edge k+1.
- R5: With lateRelease = 1 and the shifter idle, an accepted byte keeps holdEmpty low until the clock edge of the baud tick that ends its start bit. holdEmpty is high after that edge.
- R6: If the holding register is full when a stop bit ends, the next start bit begins on that same baud tick with no idle period, and txDone stays 0.
- R7: txDone is set on the clock edge of the baud tick that ends a stop bit, provided the holding register is empty at that edge.
- R8: txDone keeps its value until doneClr is high at a clock edge or a byte is accepted. An accepted byte clears it even if it would be set on the same edge.
- R9: A write while holdEmpty is 0 is dropped and sets overrun. overrun stays set until reset.
- R10: With lateRelease = 0, a byte written while a frame is in progress stays in the holding register until the baud tick that ends that frame's stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| lateRelease | input | 1 | 0: early release, 1: release at end of start bit |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to send |
| emptyIrqEn | input | 1 | Holding-empty interrupt enable |
| doneIrqEn | input | 1 | Done interrupt enable |
| doneClr | input | 1 | Clears txDone |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding register can take a byte |
| txDone | output | 1 | All frames sent, nothing waiting |
| overrun | output | 1 | Sticky flag for a dropped write |
| emptyIrq | output | 1 | Holding-empty interrupt |
| doneIrq | output | 1 | Done interrupt |

## Verification
The interrupt outputs are due in the same cycle as their inputs, so the bench checks them a moment after it changes an enable. holdEmpty changes one edge after the write edge. In early release it returns one edge later. In late release it returns on the edge of the tick that ends the start bit, and the bench finds that edge by watching for a tick while the line is low. Line bits and txDone change on the clock edge that carries a baud tick. The bench's frame decoder therefore samples on the falling clock edge after each tick edge, which is where it reads each bit, the gap after a stop bit, and the value of txDone at the end of a frame.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_START,
    PH_DATA,
    PH_STOP
  } phase_e;

  typedef enum logic [2:0] {
    LINE_KEEP,
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_STOP
  } lineCmd_e;

  typedef struct packed {
    logic     holdWrite;
    logic     holdTake;
    lineCmd_e lineCmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              holdFull,
  output logic              txLine
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] srcByte;
  logic              holdValid;
  logic              lineReg;

  // A byte taken on the same edge as its first data bit comes straight from the holding register.
  assign srcByte = strb.holdTake ? holdData : shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
    end else if (strb.holdWrite) begin
      holdValid <= 1'b1;
      holdData  <= wrData;
    end else if (strb.holdTake) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      lineReg  <= 1'b1;
    end else begin
      if (strb.lineCmd == LINE_DATA) begin
        shiftReg <= {1'b0, srcByte[DATA_W-1:1]};
      end else if (strb.holdTake) begin
        shiftReg <= holdData;
      end
      case (strb.lineCmd)
        LINE_START: lineReg <= 1'b0;
        LINE_DATA:  lineReg <= srcByte[0];
        LINE_STOP:  lineReg <= 1'b1;
        LINE_IDLE:  lineReg <= 1'b1;
        default:    lineReg <= lineReg;
      endcase
    end
  end

  assign holdFull = holdValid;
  assign txLine   = lineReg;

endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick,
  input  logic        lateRelease,
  input  logic        wrEn,
  input  logic        doneClr,
  input  logic        holdFull,
  output ctrlStrobe_t strb,
  output logic        txDone,
  output logic        overrun
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_e          phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic            loaded, loadedNext;
  logic            doneReg, overReg;
  logic            accept, setDone;

  assign accept = wrEn && !holdFull;

  always_comb begin
    phaseNext      = phase;
    bitCntNext     = bitCnt;
    loadedNext     = loaded;
    setDone        = 1'b0;
    strb.holdWrite = accept;
    strb.holdTake  = 1'b0;
    strb.lineCmd   = LINE_KEEP;
    case (phase)
      PH_IDLE: begin
        if (holdFull) begin
          phaseNext = PH_ARM;
          if (!lateRelease) begin
            strb.holdTake = 1'b1;
            loadedNext    = 1'b1;
          end
        end
      end
      PH_ARM: begin
        if (baudTick) begin
          phaseNext    = PH_START;
          strb.lineCmd = LINE_START;
        end
      end
      PH_START: begin
        if (baudTick) begin
          phaseNext    = PH_DATA;
          bitCntNext   = '0;
          strb.lineCmd = LINE_DATA;
          if (!loaded) begin
            strb.holdTake = 1'b1;
            loadedNext    = 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (baudTick) begin
          if (bitCnt == LAST_BIT) begin
            phaseNext    = PH_STOP;
            strb.lineCmd = LINE_STOP;
          end else begin
            bitCntNext   = bitCnt + 1'b1;
            strb.lineCmd = LINE_DATA;
          end
        end
      end
      PH_STOP: begin
        if (baudTick) begin
          loadedNext = 1'b0;
          if (holdFull) begin
            phaseNext    = PH_START;
            strb.lineCmd = LINE_START;
            if (!lateRelease) begin
              strb.holdTake = 1'b1;
              loadedNext    = 1'b1;
            end
          end else begin
            phaseNext    = PH_IDLE;
            strb.lineCmd = LINE_IDLE;
            setDone      = 1'b1;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      loaded  <= 1'b0;
      doneReg <= 1'b0;
      overReg <= 1'b0;
    end else begin
      phase  <= phaseNext;
      bitCnt <= bitCntNext;
      loaded <= loadedNext;
      if (accept)       doneReg <= 1'b0;
      else if (setDone) doneReg <= 1'b1;
      else if (doneClr) doneReg <= 1'b0;
      if (wrEn && holdFull) overReg <= 1'b1;
    end
  end

  assign txDone  = doneReg;
  assign overrun = overReg;

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              lateRelease,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              emptyIrqEn,
  input  logic              doneIrqEn,
  input  logic              doneClr,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txDone,
  output logic              overrun,
  output logic              emptyIrq,
  output logic              doneIrq
);

  ctrlStrobe_t strb;
  logic        holdFull;

  utx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lateRelease(lateRelease),
    .wrEn(wrEn), .doneClr(doneClr), .holdFull(holdFull), .strb(strb),
    .txDone(txDone), .overrun(overrun)
  );

  utx_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .holdFull(holdFull), .txLine(txLine)
  );

  assign holdEmpty = !holdFull;
  assign emptyIrq  = holdEmpty && emptyIrqEn;
  assign doneIrq   = txDone && doneIrqEn;

endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic wrEn,
  input logic doneClr,
  input logic holdEmpty,
  input logic txDone,
  input logic overrun,
  input logic txLine
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (holdEmpty && !txDone && !overrun && txLine));

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(baudTick));

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (holdEmpty && txLine));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !doneClr && !wrEn) |=> txDone);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !holdEmpty) |=> overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind uart_tx_hold uart_tx_hold_chk uChk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrEn(wrEn), .doneClr(doneClr),
  .holdEmpty(holdEmpty), .txDone(txDone), .overrun(overrun), .txLine(txLine)
);

// File: tb/tb_uart_tx_hold.sv
`timescale 1ns/100ps
module tb_uart_tx_hold;

  localparam int BAUD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic lateRelease = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic emptyIrqEn = 1'b0;
  logic doneIrqEn = 1'b0;
  logic doneClr = 1'b0;
  logic txLine, holdEmpty, txDone, overrun, emptyIrq, doneIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] expQ[$];

  int endCnt = 0;
  logic lastEndDone = 1'b0;
  logic lastGapZero = 1'b0;

  uart_tx_hold dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lateRelease(lateRelease),
    .wrEn(wrEn), .wrData(wrData), .emptyIrqEn(emptyIrqEn), .doneIrqEn(doneIrqEn),
    .doneClr(doneClr), .txLine(txLine), .holdEmpty(holdEmpty), .txDone(txDone),
    .overrun(overrun), .emptyIrq(emptyIrq), .doneIrq(doneIrq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic irqModel(input logic flag, input logic en);
    return flag & en;
  endfunction

  // Baud tick generator: one pulse every BAUD clocks, changed at falling edges.
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      cycles++;
      tcnt++;
      baudTick = (tcnt % BAUD == 0);
    end
  end

  // Frame decoder: reads the line after each tick edge.
  initial begin
    int rxPhase = 0;
    int rxCnt = 0;
    logic [7:0] rxByte = 8'h00;
    logic justStopped = 1'b0;
    forever begin
      @(posedge clk);
      if (baudTick && rstN) begin
        @(negedge clk);
        if (justStopped) begin
          lastEndDone = txDone;
          lastGapZero = (txLine == 1'b0);
          justStopped = 1'b0;
          endCnt++;
        end
        case (rxPhase)
          0: if (txLine == 1'b0) begin rxPhase = 1; rxCnt = 0; end
          1: begin
            rxByte[rxCnt] = txLine;
            rxCnt++;
            if (rxCnt == 8) rxPhase = 2;
          end
          default: begin
            chk("R2 stop bit", txLine, 1'b1);
            if (expQ.size() == 0) chk("R2 unexpected frame", rxByte, 32'hFFFF);
            else chk("R2 frame data", rxByte, expQ.pop_front());
            rxPhase = 0;
            justStopped = 1'b1;
          end
        endcase
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic writeByte(input logic [7:0] b);
    if (holdEmpty) expQ.push_back(b);
    wrEn = 1'b1;
    wrData = b;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitEnd(input int target);
    while (endCnt < target && cycles < 150000) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 line", txLine, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 holdEmpty", holdEmpty, 1'b1);
    chk("R1 txDone", txDone, 1'b0);
    chk("R1 overrun", overrun, 1'b0);
    chk("R1 txLine", txLine, 1'b1);

    // R3: level interrupt fires as soon as enabled.
    chk("R3 emptyIrq off", emptyIrq, 1'b0);
    emptyIrqEn = 1'b1;
    doneIrqEn = 1'b1;
    #1;
    chk("R3 emptyIrq on", emptyIrq, irqModel(1'b1, 1'b1));
    chk("R3 doneIrq", doneIrq, irqModel(txDone, 1'b1));

    // R4: early release.
    lateRelease = 1'b0;
    writeByte(8'hA5);
    chk("R4 holdEmpty low", holdEmpty, 1'b0);
    chk("R3 emptyIrq low", emptyIrq, 1'b0);
    @(negedge clk);
    chk("R4 holdEmpty back", holdEmpty, 1'b1);
    waitEnd(1);
    chk("R7 done after frame", lastEndDone, 1'b1);
    chk("R7 no gap expected", lastGapZero, 1'b0);
    chk("R3 doneIrq set", doneIrq, 1'b1);
    repeat (20) @(negedge clk);
    chk("R8 done held", txDone, 1'b1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk("R8 done cleared", txDone, 1'b0);

    // R5: late release, all-ones byte.
    lateRelease = 1'b1;
    writeByte(8'hFF);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      logic wasTick, wasStart;
      if (holdEmpty !== 1'b0) bad++;
      @(posedge clk);
      wasTick = baudTick;
      wasStart = (txLine == 1'b0);
      @(negedge clk);
      if (wasTick && wasStart) break;
    end
    chk("R5 held through start bit", bad, 0);
    chk("R5 released after start", holdEmpty, 1'b1);
    waitEnd(2);

    // R10 and R6: early release, second byte during a frame.
    lateRelease = 1'b0;
    writeByte(8'h3C);
    while (!holdEmpty) @(negedge clk);
    writeByte(8'hC3);
    repeat (30) @(negedge clk);
    chk("R10 byte waits", holdEmpty, 1'b0);
    writeByte(8'h99);
    chk("R9 overrun set", overrun, 1'b1);
    waitEnd(3);
    chk("R6 no idle gap", lastGapZero, 1'b1);
    chk("R6 done stays low", lastEndDone, 1'b0);
    waitEnd(4);
    chk("R7 done after pair", lastEndDone, 1'b1);

    // R8: a write clears done.
    writeByte(8'h5A);
    chk("R8 write clears done", txDone, 1'b0);
    waitEnd(5);

    // Random phase.
    for (int n = 0; n < 40; n++) begin
      lateRelease = $urandom_range(0, 1);
      repeat ($urandom_range(0, 30)) @(negedge clk);
      if (holdEmpty) begin
        writeByte(8'($urandom));
      end else begin
        writeByte(8'($urandom));
        chk("R9 overrun sticky", overrun, 1'b1);
      end
    end
    while (expQ.size() != 0 && cycles < 150000) @(negedge clk);
    repeat (3 * BAUD) @(negedge clk);
    chk("R7 done at end", txDone, 1'b1);
    chk("R2 all frames out", expQ.size(), 0);
    chk("R9 overrun kept", overrun, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule